// File: doc/BRIEF.md
# DMA Descriptor Queue with Automatic Reload

This block holds a short queue of pending DMA descriptors in front of one live DMA channel. The live channel is a configuration word and an address word that a DMA engine reads. Software loads a descriptor in two steps. It first writes a staging address register. It then writes a queue command register, and that write places the command and the staged address into the queue together as one entry. Software can also program the live configuration and address registers directly to start a transfer.

When the engine reports a clean finish, the block moves the oldest queued descriptor into the live registers and keeps the channel enabled, so the next transfer starts at once. When the queue is empty at a clean finish, the channel stops. An error finish stops the channel and leaves the queue untouched, so software can inspect the queue and then restart or flush it.

While a transfer runs, the engine steps the live address forward. The swap, endian and direction bits are only stored and forwarded to the engine. A two-bit interrupt register drives a level interrupt. Software clears its bits by writing ones to the register, and it sets them by writing ones to a second alias.

Top module: `dma_desc_queue`

## Requirements
- R1: After reset, every register reads zero: queue status, staging address, live configuration, live address and interrupt bits. The interrupt output is low.
- R2: A write to the command register (offset 2) appends one entry, made of the written command and the current staging address. Queue status bits 4:0 show the entry count, and each write raises it by one.
- R3: The staging register (offset 1) keeps only bits 41:3 of a write, so a staged address is 8-byte aligned. All other bits read as zero.
- R4: An entry keeps only these command fields: direction at bit 62, no-interrupt at bit 60, three swap bits at 59:57, endian at 56 and a 20-bit size at 55:36. All other written bits are dropped.
- R5: The queue holds 16 entries. A command write to a full queue is discarded, and the count stays at 16.
- R6: A clean finish while the channel is enabled and the queue is not empty loads the oldest entry, one cycle later. Its fields go into the live configuration (offset 3) with the enable bit 63 set, and its address goes into the live address (offset 4). The count drops by one, and entries leave in the order they were written.
- R7: A clean finish with an empty queue clears the enable bit and leaves the other live configuration fields unchanged.
- R8: An error finish clears the enable bit. It does not dequeue and sets no interrupt bit. An error on the same cycle as a finish counts as an error.
- R9: Finish and error inputs have no effect while the enable bit is clear.
- R10: A write to queue status (offset 0) sets the interrupt threshold from bits 12:8. When bit 16 is one, the write also empties the queue. Bit 16 always reads back as zero.
- R11: Interrupt bit 0 is set on each clean finish, unless the live configuration that just finished had its no-interrupt bit set.
- R12: Interrupt bit 1 is set when a dequeue leaves the count at or below the threshold.
- R13: Writing ones to the interrupt register (offset 5) clears those bits. Writing ones to the alias (offset 6) sets them. The interrupt output is high whenever either bit is set.
- R14: Each cycle with the advance input high and the channel enabled, the live address grows by 8. Advance has no effect while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data for regAddr (combinational) |
| dmaDone | input | 1 | Engine reports a finished transfer |
| dmaErr | input | 1 | Engine reports a failed transfer |
| adrAdvance | input | 1 | Engine consumed 8 bytes; step the live address |
| actCfgWord | output | 64 | Live configuration word, with the enable bit at 63 |
| actAdr | output | 42 | Live transfer address |
| irq | output | 1 | Level interrupt |

## Verification
Every register write, finish, error or advance pulse takes effect at the first rising edge after it is driven. The next read of the register, and the matching output, already shows the new value. The bench drives each stimulus for a single cycle between falling edges and reads at the following falling edge. By then exactly one register stage has updated, and no second event has begun. A dequeue and the interrupt bits it sets land on the same edge, so the bench checks them together in a single read pass.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  localparam logic [2:0] OFS_QSTAT = 3'd0;
  localparam logic [2:0] OFS_STAGE = 3'd1;
  localparam logic [2:0] OFS_QCMD  = 3'd2;
  localparam logic [2:0] OFS_LCFG  = 3'd3;
  localparam logic [2:0] OFS_LADR  = 3'd4;
  localparam logic [2:0] OFS_INT   = 3'd5;
  localparam logic [2:0] OFS_INTS  = 3'd6;

  localparam int ADR_W   = 42;
  localparam int STAGE_W = 39;
  localparam int LVL_W   = 5;

  typedef struct packed {
    logic        dir;
    logic        noIrq;
    logic [2:0]  swap;
    logic        endian;
    logic [19:0] size;
  } cmdFields_t;

  typedef struct packed {
    cmdFields_t          cmd;
    logic [STAGE_W-1:0]  adr;
  } entry_t;

  typedef struct packed {
    logic       push;
    logic       pop;
    logic       stop;
    logic       clrQ;
    logic       wrLvl;
    logic       wrStage;
    logic       wrLiveCfg;
    logic       wrLiveAdr;
    logic       advance;
    logic [1:0] intSet;
    logic [1:0] intClr;
  } strobes_t;

  function automatic cmdFields_t decodeCmd(input logic [63:0] d);
    cmdFields_t c;
    c.dir    = d[62];
    c.noIrq  = d[60];
    c.swap   = d[59:57];
    c.endian = d[56];
    c.size   = d[55:36];
    return c;
  endfunction
endpackage

// File: rtl/dmaq_ctrl.sv
module dmaq_ctrl
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [63:0]      regWrData,
  input  logic             dmaDone,
  input  logic             dmaErr,
  input  logic             adrAdvance,
  input  logic             liveEn,
  input  logic             liveNoIrq,
  input  logic [CNT_W-1:0] qCount,
  input  logic [LVL_W-1:0] qLvl,
  output strobes_t         strb
);
  logic wrQstat, wrCmd, wrInt, wrIntSet, swLive;
  logic cleanEnd, badEnd, haveEntry, qFull, popNow;

  always_comb begin
    wrQstat   = regWrEn && (regAddr == OFS_QSTAT);
    wrCmd     = regWrEn && (regAddr == OFS_QCMD);
    wrInt     = regWrEn && (regAddr == OFS_INT);
    wrIntSet  = regWrEn && (regAddr == OFS_INTS);
    swLive    = regWrEn && ((regAddr == OFS_LCFG) || (regAddr == OFS_LADR));
    badEnd    = liveEn && dmaErr;
    cleanEnd  = liveEn && dmaDone && !dmaErr;
    haveEntry = (qCount != '0);
    qFull     = (int'(qCount) >= DEPTH);
    popNow    = cleanEnd && haveEntry && !swLive;

    strb           = '0;
    strb.pop       = popNow;
    strb.stop      = badEnd || (cleanEnd && !haveEntry);
    strb.push      = wrCmd && (!qFull || popNow);
    strb.clrQ      = wrQstat && regWrData[16];
    strb.wrLvl     = wrQstat;
    strb.wrStage   = regWrEn && (regAddr == OFS_STAGE);
    strb.wrLiveCfg = regWrEn && (regAddr == OFS_LCFG);
    strb.wrLiveAdr = regWrEn && (regAddr == OFS_LADR);
    strb.advance   = liveEn && adrAdvance;
    strb.intSet[0] = (cleanEnd && !liveNoIrq) || (wrIntSet && regWrData[0]);
    strb.intSet[1] = (popNow && (int'(qCount) <= int'(qLvl) + 1))
                     || (wrIntSet && regWrData[1]);
    strb.intClr    = wrInt ? regWrData[1:0] : 2'b00;
  end
endmodule

// File: rtl/dmaq_datapath.sv
module dmaq_datapath
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic [2:0]       regAddr,
  input  logic [63:0]      regWrData,
  output logic [63:0]      regRdData,
  output logic [CNT_W-1:0] qCount,
  output logic [LVL_W-1:0] qLvl,
  output logic             liveEn,
  output logic             liveNoIrq,
  output logic [63:0]      actCfgWord,
  output logic [ADR_W-1:0] actAdr,
  output logic             irq
);
  entry_t             mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [STAGE_W-1:0] stage;
  cmdFields_t         liveCmd;
  logic [1:0]         intBits;
  entry_t             head;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= '{cmd: decodeCmd(regWrData), adr: stage};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
      qLvl   <= '0;
      stage  <= '0;
    end else begin
      if (strb.wrLvl)   qLvl  <= regWrData[12:8];
      if (strb.wrStage) stage <= regWrData[41:3];
      if (strb.clrQ) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        qCount <= '0;
      end else begin
        if (strb.push) wrPtr <= nextPtr(wrPtr);
        if (strb.pop)  rdPtr <= nextPtr(rdPtr);
        qCount <= qCount + CNT_W'(strb.push) - CNT_W'(strb.pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveEn  <= 1'b0;
      liveCmd <= '0;
      actAdr  <= '0;
      intBits <= '0;
    end else begin
      if (strb.wrLiveCfg) begin
        liveEn  <= regWrData[63];
        liveCmd <= decodeCmd(regWrData);
      end else if (strb.pop) begin
        liveEn  <= 1'b1;
        liveCmd <= head.cmd;
      end else if (strb.stop) begin
        liveEn  <= 1'b0;
      end

      if (strb.wrLiveAdr)    actAdr <= regWrData[ADR_W-1:0];
      else if (strb.pop)     actAdr <= {head.adr, 3'b000};
      else if (strb.advance) actAdr <= actAdr + ADR_W'(8);

      intBits <= (intBits & ~strb.intClr) | strb.intSet;
    end
  end

  assign liveNoIrq  = liveCmd.noIrq;
  assign actCfgWord = {liveEn, liveCmd.dir, 1'b0, liveCmd.noIrq, liveCmd.swap,
                       liveCmd.endian, liveCmd.size, 36'd0};
  assign irq        = |intBits;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_QSTAT: begin
        regRdData[12:8]        = qLvl;
        regRdData[CNT_W-1:0]   = qCount;
      end
      OFS_STAGE: regRdData[41:3]        = stage;
      OFS_LCFG:  regRdData              = actCfgWord;
      OFS_LADR:  regRdData[ADR_W-1:0]   = actAdr;
      OFS_INT, OFS_INTS: regRdData[1:0] = intBits;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/dma_desc_queue.sv
module dma_desc_queue
  import dmaq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [63:0]      regWrData,
  output logic [63:0]      regRdData,
  input  logic             dmaDone,
  input  logic             dmaErr,
  input  logic             adrAdvance,
  output logic [63:0]      actCfgWord,
  output logic [ADR_W-1:0] actAdr,
  output logic             irq
);
  strobes_t         strb;
  logic [CNT_W-1:0] qCount;
  logic [LVL_W-1:0] qLvl;
  logic             liveEn, liveNoIrq;

  dmaq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .dmaDone(dmaDone), .dmaErr(dmaErr), .adrAdvance(adrAdvance),
    .liveEn(liveEn), .liveNoIrq(liveNoIrq), .qCount(qCount), .qLvl(qLvl),
    .strb(strb)
  );

  dmaq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .qCount(qCount),
    .qLvl(qLvl), .liveEn(liveEn), .liveNoIrq(liveNoIrq),
    .actCfgWord(actCfgWord), .actAdr(actAdr), .irq(irq)
  );
endmodule

// File: rtl/dma_desc_queue_chk.sv
module dma_desc_queue_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic             dmaDone,
  input logic             dmaErr,
  input logic [63:0]      actCfgWord,
  input logic [41:0]      actAdr,
  input logic [CNT_W-1:0] qCount,
  input logic             irq
);
  logic en;
  assign en = actCfgWord[63];

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(qCount) <= DEPTH);

  a_r8_err_holds_queue: assert property (@(posedge clk) disable iff (!rstN)
    (en && dmaErr && !regWrEn) |=> (qCount == $past(qCount) && !actCfgWord[63]));

  a_r6_pop_reloads: assert property (@(posedge clk) disable iff (!rstN)
    (en && dmaDone && !dmaErr && qCount != '0 && !regWrEn)
      |=> (actCfgWord[63] && qCount == $past(qCount) - 1'b1));

  a_r7_empty_stops: assert property (@(posedge clk) disable iff (!rstN)
    (en && dmaDone && !dmaErr && qCount == '0 && !regWrEn) |=> !actCfgWord[63]);

  a_r14_idle_adr_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !regWrEn) |=> $stable(actAdr));

  a_r13_irq_fall_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(regWrEn && regAddr == 3'd5));
endmodule

bind dma_desc_queue dma_desc_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .dmaDone(dmaDone), .dmaErr(dmaErr), .actCfgWord(actCfgWord),
  .actAdr(actAdr), .qCount(qCount), .irq(irq)
);

// File: tb/dma_desc_queue_tb.sv
`timescale 1ns/1ps
module dma_desc_queue_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        dmaDone = 1'b0, dmaErr = 1'b0, adrAdvance = 1'b0;
  logic [63:0] actCfgWord;
  logic [41:0] actAdr;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  localparam logic [63:0] ADR_MASK = 64'h0000_03FF_FFFF_FFF8;
  localparam logic [63:0] EN_BIT   = 64'h8000_0000_0000_0000;

  dma_desc_queue u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .dmaDone(dmaDone),
    .dmaErr(dmaErr), .adrAdvance(adrAdvance), .actCfgWord(actCfgWord),
    .actAdr(actAdr), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [63:0] mkCmd(input logic dir, input logic noIrq,
      input logic [2:0] sw, input logic en, input logic [19:0] sz);
    return {1'b0, dir, 1'b0, noIrq, sw, en, sz, 36'd0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [63:0] exp);
    regAddr = a;
    #0.1;
    check(req, regRdData, exp);
  endtask

  task automatic pulse(input logic d, input logic e, input logic adv);
    dmaDone = d; dmaErr = e; adrAdvance = adv;
    @(negedge clk);
    dmaDone = 1'b0; dmaErr = 1'b0; adrAdvance = 1'b0;
  endtask

  logic [63:0] c1, c2, s1, s2;

  task automatic t_reset;
    rd("R1 qstat", 3'd0, 64'd0);
    rd("R1 stage", 3'd1, 64'd0);
    rd("R1 lcfg", 3'd3, 64'd0);
    rd("R1 ladr", 3'd4, 64'd0);
    rd("R1 int", 3'd5, 64'd0);
    check("R1 irq", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_push;
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R3 stage mask", 3'd1, ADR_MASK);
    wr(3'd1, s1);
    rd("R3 stage value", 3'd1, s1 & ADR_MASK);
    wr(3'd2, c1);
    rd("R2 count one", 3'd0, 64'd1);
    wr(3'd1, s2);
    wr(3'd2, c2);
    rd("R2 count two", 3'd0, 64'd2);
  endtask

  task automatic t_advance_err;
    wr(3'd4, 64'h1000);
    wr(3'd3, EN_BIT);
    pulse(1'b0, 1'b0, 1'b1);
    pulse(1'b0, 1'b0, 1'b1);
    rd("R14 advance", 3'd4, 64'h1010);
    pulse(1'b1, 1'b1, 1'b0);
    rd("R8 no pop", 3'd0, 64'd2);
    check("R8 en cleared", {63'd0, actCfgWord[63]}, 64'd0);
    rd("R8 no int", 3'd5, 64'd0);
    pulse(1'b0, 1'b0, 1'b1);
    rd("R14 idle advance", 3'd4, 64'h1010);
    pulse(1'b1, 1'b0, 1'b0);
    rd("R9 idle done count", 3'd0, 64'd2);
    rd("R9 idle done int", 3'd5, 64'd0);
  endtask

  task automatic t_reload;
    wr(3'd0, 64'h100);
    rd("R10 lvl", 3'd0, 64'h102);
    wr(3'd3, EN_BIT);
    pulse(1'b1, 1'b0, 1'b0);
    rd("R6 R4 lcfg first", 3'd3, EN_BIT | mkCmd(1, 1, 3'b101, 1, 20'hABCDE));
    rd("R6 ladr first", 3'd4, s1 & ADR_MASK);
    rd("R6 count", 3'd0, 64'h101);
    rd("R11 R12 int", 3'd5, 64'd3);
    check("R13 irq high", {63'd0, irq}, 64'd1);
    wr(3'd5, 64'd3);
    rd("R13 w1c", 3'd5, 64'd0);
    check("R13 irq low", {63'd0, irq}, 64'd0);
    pulse(1'b1, 1'b0, 1'b0);
    rd("R6 lcfg second", 3'd3, EN_BIT | c2);
    rd("R6 ladr second", 3'd4, s2 & ADR_MASK);
    rd("R11 suppressed R12 set", 3'd5, 64'd2);
    wr(3'd5, 64'd2);
    pulse(1'b1, 1'b0, 1'b0);
    rd("R7 stop keeps fields", 3'd3, c2);
    rd("R11 done only", 3'd5, 64'd1);
    wr(3'd6, 64'd2);
    rd("R13 w1s", 3'd6, 64'd3);
    wr(3'd5, 64'd3);
    rd("R13 cleared", 3'd5, 64'd0);
  endtask

  task automatic t_full;
    wr(3'd0, 64'h1_0000);
    for (int i = 0; i < 17; i++) begin
      wr(3'd1, 64'(i + 1) * 64);
      wr(3'd2, mkCmd(0, 1, 3'b000, 0, 20'(i)));
    end
    rd("R5 saturate", 3'd0, 64'd16);
    wr(3'd4, 64'd0);
    wr(3'd3, EN_BIT | mkCmd(0, 1, 3'b000, 0, 20'd0));
    for (int i = 0; i < 16; i++) begin
      pulse(1'b1, 1'b0, 1'b0);
      rd("R5 R6 order adr", 3'd4, 64'(i + 1) * 64);
      rd("R5 R6 order cfg", 3'd3, EN_BIT | mkCmd(0, 1, 3'b000, 0, 20'(i)));
    end
    rd("R5 drained", 3'd0, 64'd0);
    pulse(1'b1, 1'b0, 1'b0);
    check("R7 stop after drain", {63'd0, actCfgWord[63]}, 64'd0);
    wr(3'd5, 64'd3);
  endtask

  task automatic t_clear;
    for (int i = 0; i < 3; i++) wr(3'd2, c2);
    rd("R10 before clear", 3'd0, 64'd3);
    wr(3'd0, 64'h1_0400);
    rd("R10 cleared lvl4 bit16 zero", 3'd0, 64'h400);
  endtask

  initial begin
    c1 = mkCmd(1, 1, 3'b101, 1, 20'hABCDE) | 64'hA000_000F_FFFF_FFFF;
    c2 = mkCmd(0, 0, 3'b010, 0, 20'h00123);
    s1 = 64'hF000_0123_4567_89AF;
    s2 = 64'h0000_0000_0000_2468;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_push();
    t_advance_err();
    t_reload();
    t_full();
    t_clear();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule